// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one external bus transfer at a time for a 16-bit processor core with a 20-bit address space. The core presents a read or write request, either to memory or to I/O. The block accepts it and plays it out over a shared address/data bus. The low address half travels on the same lines as the data. The four upper address lines carry status once the address phase is over. A latch pulse tells external logic when to capture the address.

Each transfer runs through four clock states. Extra wait states are added while the addressed slave reports that it is not ready. The block drives the read, write, direction, data-enable, memory/I/O and high-byte-enable strobes. It also arbitrates the bus with an external DMA master. A hold request is honoured only between transfers. While the hold is granted, every bus and control output is released.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While `rst_n` is low, and on leaving reset: `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `hlda`=0, `ad_oe`=0, `io_m`=0, `dt_r`=1, `ctl_oe`=1, `as_out`=0, and the sequencer is idle.
- R2: A request is accepted (`req_ack`=1) in the cycle where `req_valid` is high, the sequencer is idle or in T4, and `hold` is low. The transfer then spends one cycle each in T1, T2 and T3, plus any wait cycles, then one cycle in T4. `rsp_valid` is high exactly in T4.
- R3: `ale` is high only in T1. In T1, `ad_oe`=1, `ad_out` carries address bits 15:0, and `as_out` carries address bits 19:16.
- R4: From T2 through T4, `as_out` carries status: bit 3 = 0, bit 2 = the request's interrupt-enable flag, and bits 1:0 = the request's segment code.
- R5: `ready` is sampled only at the end of T3 and of each wait cycle. A low sample adds a wait cycle that keeps the data-phase strobes active. The first high sample leads to T4. A low `ready` at any other time has no effect.
- R6: In a read, `rd_n` is low from T2 through the last wait cycle, `ad_oe` is 0 from T2 to T4, and `rsp_rdata` in T4 equals `ad_in` at the sampling edge that ended the data phase. In a write, `wr_n` is low over the same span, and `ad_oe`=1 with `ad_out` = write data from T2 to T4.
- R7: `dt_r` is 1 for a write and 0 for a read from T1 to T4, and 1 otherwise. `den_n` is low only from T2 through the last wait cycle.
- R8: From T1 to T4, `io_m` is 0 for a memory transfer and 1 for an I/O transfer. It is 0 otherwise.
- R9: From T1 to T4, `bhe_n` is 0 when the request uses the high data byte (`req_hi_byte`=1). It is 1 otherwise.
- R10: `hold` is acted on only when idle or at the end of T4. A transfer in progress completes first. In the next cycle `hlda`=1, `ad_oe`=0 and `ctl_oe`=0, and no request is accepted while the hold lasts.
- R11: The first clock edge that samples `hold` low while it is granted drops `hlda` and restores `ctl_oe`=1. From that cycle, requests can be accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Core requests a transfer; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_hi_byte | input | 1 | High data byte takes part |
| req_seg | input | 2 | Segment code shown as status |
| req_ien | input | 1 | Interrupt-enable flag shown as status |
| req_ack | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Transfer in T4 |
| rsp_rdata | output | 16 | Read data captured for the transfer |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_in | input | 16 | Shared address/data lines, received value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| as_out | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| dt_r | output | 1 | Data direction, 1 = transmit |
| den_n | output | 1 | Data buffer enable, active low |
| bhe_n | output | 1 | High byte enable, active low |
| ctl_oe | output | 1 | Drive enable for `as_out` and all strobes |
| ready | input | 1 | Slave ready |
| hold | input | 1 | DMA master bus request |
| hlda | output | 1 | Bus granted to DMA master |

## Verification
The bench targets these corner cases:

- **Back-to-back requests.** A second request accepted at the end of T4 must reach T1 directly. A design that passed through idle would add a dead cycle and misalign every later strobe.
- **`ready` pulled low outside the sampling states.** A design that sampled it in T2 would stretch a zero-wait transfer.
- **Several wait cycles, then the read data.** The data must come from the edge that ends the data phase. Capturing it on an earlier edge returns stale data.
- **`hold` raised in the middle of a stretched transfer.** The transfer must complete before the grant. A design that granted early would float `rd_n` while the slave still drives the bus.
- **A request pending across a hold and its release.** It must be refused until `hlda` has dropped, and `hlda` must drop one clock after release.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HELD
  } bus_st_e;

  typedef struct packed {
    logic       write;
    logic       io;
    logic       hi_byte;
    logic [1:0] seg;
    logic       ien;
  } xfer_attr_t;

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold,
  input  logic    ready,
  output bus_st_e st,
  output logic    accept,
  output logic    cap_rd
);

  bus_st_e st_nxt;

  always_comb begin
    st_nxt = st;
    accept = 1'b0;
    cap_rd = 1'b0;
    case (st)
      ST_IDLE: begin
        if (hold) begin
          st_nxt = ST_HELD;
        end else if (req_valid) begin
          accept = 1'b1;
          st_nxt = ST_T1;
        end
      end
      ST_T1: st_nxt = ST_T2;
      ST_T2: st_nxt = ST_T3;
      ST_T3, ST_TW: begin
        if (ready) begin
          cap_rd = 1'b1;
          st_nxt = ST_T4;
        end else begin
          st_nxt = ST_TW;
        end
      end
      ST_T4: begin
        if (hold) begin
          st_nxt = ST_HELD;
        end else if (req_valid) begin
          accept = 1'b1;
          st_nxt = ST_T1;
        end else begin
          st_nxt = ST_IDLE;
        end
      end
      ST_HELD: if (!hold) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/mbus_req_reg.sv
module mbus_req_reg
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          cap_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  xfer_attr_t    req_attr,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output xfer_attr_t    attr_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      attr_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      attr_q  <= req_attr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= ad_in;
  end

endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  bus_st_e          st,
  input  logic [AW-1:0]    addr_q,
  input  logic [DW-1:0]    wdata_q,
  input  xfer_attr_t       attr_q,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] as_out,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic             dt_r,
  output logic             den_n,
  output logic             bhe_n,
  output logic             ctl_oe,
  output logic             rsp_valid
);

  localparam int HW = AW - DW;

  logic          addr_ph;
  logic          strobe_ph;
  logic          data_ph;
  logic          in_xfer;
  logic [HW-1:0] status;

  assign addr_ph   = (st == ST_T1);
  assign strobe_ph = (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  assign data_ph   = strobe_ph || (st == ST_T4);
  assign in_xfer   = addr_ph || data_ph;

  always_comb begin
    status    = '0;
    status[2] = attr_q.ien;
    status[1:0] = attr_q.seg;
  end

  always_comb begin
    ale       = addr_ph;
    ad_oe     = addr_ph || (attr_q.write && data_ph);
    ad_out    = addr_ph ? addr_q[DW-1:0] : wdata_q;
    as_out    = addr_ph ? addr_q[AW-1:DW] : (data_ph ? status : '0);
    rd_n      = !(strobe_ph && !attr_q.write);
    wr_n      = !(strobe_ph && attr_q.write);
    den_n     = !strobe_ph;
    dt_r      = in_xfer ? attr_q.write : 1'b1;
    io_m      = in_xfer && attr_q.io;
    bhe_n     = !(in_xfer && attr_q.hi_byte);
    ctl_oe    = (st != ST_HELD);
    rsp_valid = (st == ST_T4);
  end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_io,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_hi_byte,
  input  logic [1:0]       req_seg,
  input  logic             req_ien,
  output logic             req_ack,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [DW-1:0]    ad_out,
  input  logic [DW-1:0]    ad_in,
  output logic             ad_oe,
  output logic [AW-DW-1:0] as_out,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic             dt_r,
  output logic             den_n,
  output logic             bhe_n,
  output logic             ctl_oe,
  input  logic             ready,
  input  logic             hold,
  output logic             hlda
);

  bus_st_e       st;
  logic          accept;
  logic          cap_rd;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  xfer_attr_t    attr_q;
  xfer_attr_t    req_attr;

  assign req_attr = '{write: req_write, io: req_io, hi_byte: req_hi_byte,
                      seg: req_seg, ien: req_ien};

  mbus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hold      (hold),
    .ready     (ready),
    .st        (st),
    .accept    (accept),
    .cap_rd    (cap_rd)
  );

  mbus_req_reg #(.AW(AW), .DW(DW)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cap_rd    (cap_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_attr  (req_attr),
    .ad_in     (ad_in),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .attr_q    (attr_q),
    .rdata_q   (rsp_rdata)
  );

  mbus_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .st        (st),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .attr_q    (attr_q),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .as_out    (as_out),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .dt_r      (dt_r),
    .den_n     (den_n),
    .bhe_n     (bhe_n),
    .ctl_oe    (ctl_oe),
    .rsp_valid (rsp_valid)
  );

  assign req_ack = accept;
  assign hlda    = (st == ST_HELD);

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic ready,
  input logic hold,
  input logic hlda,
  input logic ad_oe,
  input logic ctl_oe,
  input logic req_ack
);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);                                             // R3
  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wr_n));                                 // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));                                        // R6
  AST_DEN_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> (!rd_n || !wr_n));                              // R7
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !ready) |=> !den_n);                            // R5
  AST_HELD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !ctl_oe && !req_ack));                 // R10
  AST_HLDA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);                                // R11

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ale     (ale),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .den_n   (den_n),
  .ready   (ready),
  .hold    (hold),
  .hlda    (hlda),
  .ad_oe   (ad_oe),
  .ctl_oe  (ctl_oe),
  .req_ack (req_ack)
);

// File: tb/mbus_cycle_seq_tb.sv
module mbus_cycle_seq_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, req_valid, req_write, req_io, req_hi_byte, req_ien;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, ad_in;
  logic [1:0]  req_seg;
  logic        ready, hold;
  logic        req_ack, rsp_valid, ad_oe, ale, rd_n, wr_n, io_m, dt_r, den_n, bhe_n, ctl_oe, hlda;
  logic [15:0] rsp_rdata, ad_out;
  logic [3:0]  as_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state: 0 idle, 1..4 = T1..T4, 5 wait, 6 held
  int          ph = 0;
  int          acc_cnt = 0;
  int          wl = 0;
  int          pend_waits = 0;
  logic [15:0] pend_rd = '0;
  logic        cw = 0, cio = 0, chi = 0, cien = 0;
  logic [1:0]  cseg = '0;
  logic [19:0] caddr = '0;
  logic [15:0] cdata = '0, crd = '0, rdexp = '0;

  always #(CLK_P/2) clk = ~clk;

  mbus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_hi_byte(req_hi_byte), .req_seg(req_seg), .req_ien(req_ien),
    .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .as_out(as_out),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .dt_r(dt_r),
    .den_n(den_n), .bhe_n(bhe_n), .ctl_oe(ctl_oe), .ready(ready),
    .hold(hold), .hlda(hlda)
  );

  task automatic chk(string r, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h at %0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic bit can_take();
    return (ph == 0 || ph == 4) && req_valid && !hold;
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0;
    end else begin
      case (ph)
        0, 4: begin
          if (hold) ph = 6;
          else if (req_valid) begin
            ph = 1; acc_cnt++;
            cw = req_write; cio = req_io; chi = req_hi_byte; cien = req_ien;
            cseg = req_seg; caddr = req_addr; cdata = req_wdata;
            wl = pend_waits; crd = pend_rd;
          end else ph = 0;
        end
        1: ph = 2;
        2: ph = 3;
        3, 5: begin
          if (ready) begin ph = 4; rdexp = ad_in; end
          else ph = 5;
        end
        6: if (!hold) ph = 0;
        default: ph = 0;
      endcase
    end
  end

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    bit xf, sp, dp;
    xf = (ph >= 1 && ph <= 5);
    sp = (ph == 2 || ph == 3 || ph == 5);
    dp = sp || ph == 4;
    chk("R2", "req_ack", req_ack, can_take());
    chk("R2", "rsp_valid", rsp_valid, ph == 4);
    chk("R10", "ctl_oe", ctl_oe, ph != 6);
    chk("R11", "hlda", hlda, ph == 6);
    chk("R3", "ad_oe", ad_oe, ph == 1 || (cw && dp && ph != 6));
    if (ph == 1) chk("R3", "ad_out addr", ad_out, caddr[15:0]);
    if (cw && dp) chk("R6", "ad_out wdata", ad_out, cdata);
    if (ph != 6) begin
      chk("R3", "ale", ale, ph == 1);
      if (ph == 1) chk("R3", "as_out addr", as_out, caddr[19:16]);
      else if (dp) chk("R4", "as_out status", as_out, {1'b0, cien, cseg});
      else chk("R1", "as_out idle", as_out, 4'h0);
      chk("R5", "rd_n", rd_n, !(sp && !cw));
      chk("R6", "wr_n", wr_n, !(sp && cw));
      chk("R7", "den_n", den_n, !sp);
      chk("R7", "dt_r", dt_r, xf ? cw : 1'b1);
      chk("R8", "io_m", io_m, xf && cio);
      chk("R9", "bhe_n", bhe_n, !(xf && chi));
    end
    if (ph == 4 && !cw) chk("R6", "rsp_rdata", rsp_rdata, rdexp);
  end

  // slave model: ready low except when the counted waits are used up
  always @(negedge clk) begin
    #1;
    if (ph == 3 || ph == 5) begin
      ready = (wl == 0);
      if (wl > 0) wl--;
    end else begin
      ready = 1'b0;
    end
    ad_in = crd;
  end

  task automatic do_xfer(input logic w, input logic io, input logic [19:0] a,
                         input logic [15:0] d, input logic hi, input logic [1:0] sg,
                         input logic ie, input int waits, input logic [15:0] rv);
    int start;
    @(negedge clk); #1;
    req_write = w; req_io = io; req_addr = a; req_wdata = d;
    req_hi_byte = hi; req_seg = sg; req_ien = ie;
    pend_waits = waits; pend_rd = rv;
    req_valid = 1'b1;
    start = acc_cnt;
    do @(negedge clk); while (acc_cnt == start);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_err++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hold = 1'b0; req_valid = 1'b0; req_write = 0; req_io = 0;
    req_addr = '0; req_wdata = '0; req_hi_byte = 0; req_seg = '0; req_ien = 0;
    ready = 1'b0; ad_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ale reset", ale, 0);
    chk("R1", "rd_n reset", rd_n, 1);
    chk("R1", "wr_n reset", wr_n, 1);
    chk("R1", "den_n reset", den_n, 1);
    chk("R1", "hlda reset", hlda, 0);
    chk("R1", "ad_oe reset", ad_oe, 0);
    #1 rst_n = 1'b1;

    // memory read, no waits, high byte used
    do_xfer(0, 0, 20'hA5432, 16'h0000, 1, 2'd1, 1, 0, 16'hBEEF);
    repeat (6) @(negedge clk);
    // I/O write with two waits
    do_xfer(1, 1, 20'h0F0F0, 16'h1234, 0, 2'd2, 0, 2, 16'h0000);
    repeat (8) @(negedge clk);
    // I/O read with three waits, then a back-to-back memory write
    do_xfer(0, 1, 20'hFFFF0, 16'h0000, 1, 2'd3, 1, 3, 16'h55AA);
    do_xfer(1, 0, 20'h12345, 16'hCAFE, 1, 2'd0, 1, 1, 16'h0000);
    repeat (8) @(negedge clk);

    // R10/R11: hold granted from idle with a request waiting behind it
    #1 hold = 1'b1;
    repeat (3) @(negedge clk);
    fork
      do_xfer(0, 0, 20'h00400, 16'h0000, 0, 2'd1, 0, 1, 16'h0A0B);
      begin repeat (4) @(negedge clk); #1 hold = 1'b0; end
    join
    repeat (8) @(negedge clk);

    // R10: hold raised in the middle of a stretched read
    fork
      do_xfer(0, 0, 20'h80300, 16'h0000, 1, 2'd2, 1, 3, 16'h7788);
      begin repeat (3) @(negedge clk); #1 hold = 1'b1;
            repeat (10) @(negedge clk); #1 hold = 1'b0; end
    join
    repeat (6) @(negedge clk);
    do_xfer(1, 1, 20'h50014, 16'h0011, 0, 2'd3, 0, 0, 16'h0000);
    repeat (8) @(negedge clk);
    finish_run();
  end

endmodule